// File: doc/BRIEF.md
# Oscillator Frequency Window Checker

This block judges whether a recovered bit clock runs within ±1000 ppm of the rate implied by a slower reference clock. It runs on the bit clock itself. The reference arrives as a plain digital input, so the block first synchronizes it and then detects its rising edges. The block counts bit-clock cycles across a gate of a fixed number of reference periods, then compares that count with an inclusive window around the expected value.

Two select inputs set the expected ratio of bit-clock cycles to reference cycles. The bit-rate select chooses a bit-clock divisor of 4 (higher rate) or 16 (lower rate). The reference select chooses a reference divisor of 64 (38.88 MHz reference) or 128 (19.44 MHz reference). The ratio is the reference divisor divided by the bit-rate divisor.

A passing gate raises the lock flag and releases the phase detector. A failing gate holds the phase detector off and requests that the oscillator be steered up or down. A reference that stops toggling also drops lock, and that state holds until a fresh gate passes. Lock says nothing about whether data is being tracked. It reflects only that the reference is present and that the frequency check passes.

Top module: `freq_window_chk`

## Requirements
- R1: While and directly after reset: lock=0, pd_disable=1, steer_up=0, steer_dn=0.
- R2: The measured count is the number of clk cycles from the gate-opening reference rising edge to the GATE_REFS-th following rising edge. The expected count is GATE_REFS × (D_ref / D_rate), where D_rate = 4 when rate_low=0 and 16 when rate_low=1, and D_ref = 64 when ref_half=0 and 128 when ref_half=1.
- R3: When the count lies in the inclusive window expected ± floor(expected × 1000 / 1 000 000), the gate result is lock=1, pd_disable=0, steer_up=0, steer_dn=0. This clears any earlier steer request.
- R4: A count below the window gives steer_up=1, steer_dn=0, lock=0, pd_disable=1.
- R5: A count above the window gives steer_dn=1, steer_up=0, lock=0, pd_disable=1.
- R6: steer_up and steer_dn are never high together, and pd_disable is always the inverse of lock.
- R7: Outputs change only when a gate closes or the reference is declared lost. Between those events they hold.
- R8: If no reference rising edge is seen for TIMEOUT clk cycles, the outputs go to lock=0, pd_disable=1, steer_up=0, steer_dn=0. The partial gate is discarded, and the next rising edge opens a new gate.
- R9: After reset or a lost reference, lock stays low until a complete gate has been judged in window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| rate_low | input | 1 | 0: bit-clock divisor 4; 1: divisor 16 |
| ref_half | input | 1 | 0: reference divisor 64; 1: divisor 128 |
| lock | output | 1 | Frequency inside window and reference present |
| pd_disable | output | 1 | Phase detector held off while frequency is being pulled in |
| steer_up | output | 1 | Request to raise oscillator frequency |
| steer_dn | output | 1 | Request to lower oscillator frequency |

## Verification
On every cycle, the embedded properties check the following: the two steer requests are exclusive, and the disable output mirrors lock. They also check that outputs and the gate edge tally hold between gate closes. A count under or over the window must produce the matching steer request one cycle later, and a lost reference must clear lock and steering. Only the bench scenarios can show the rest. These are the exact window edges (the last count inside and the first outside) under three different ratio settings, and the clearing of a steer after one good gate. They also cover a stalled reference that restarts gating from its next edge, and lock staying low through the first gate after reset or after the reference returns.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    localparam int unsigned WINDOW_PPM = 1000;

    typedef enum logic [1:0] {
        VERD_IN,
        VERD_LOW,
        VERD_HIGH
    } verdict_e;

    typedef struct packed {
        logic lock;
        logic pd_disable;
        logic steer_up;
        logic steer_dn;
    } ctl_out_t;

    localparam ctl_out_t CTL_IDLE = '{lock: 1'b0, pd_disable: 1'b1, steer_up: 1'b0, steer_dn: 1'b0};

    // sel[1] = reference select, sel[0] = bit-rate select
    function automatic int unsigned ratio_shift(logic [1:0] sel);
        int unsigned ref_lg;
        int unsigned rate_lg;
        ref_lg  = sel[1] ? 7 : 6;
        rate_lg = sel[0] ? 4 : 2;
        return ref_lg - rate_lg;
    endfunction

    function automatic longint unsigned gate_expect(int unsigned gate, logic [1:0] sel);
        return longint'(gate) << ratio_shift(sel);
    endfunction

    function automatic longint unsigned gate_tol(int unsigned gate, logic [1:0] sel);
        return (gate_expect(gate, sel) * WINDOW_PPM) / 1000000;
    endfunction

    function automatic ctl_out_t verdict_to_ctl(verdict_e v);
        ctl_out_t c;
        c = CTL_IDLE;
        case (v)
            VERD_IN:   begin c.lock = 1'b1; c.pd_disable = 1'b0; end
            VERD_LOW:  c.steer_up = 1'b1;
            VERD_HIGH: c.steer_dn = 1'b1;
            default:   c = CTL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fwc_ref_sync.sv
module fwc_ref_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic ref_edge
);
    // stages 0..SYNC_STAGES-1 synchronize, the last holds the previous level
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], ref_in};
    end

    assign ref_edge = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/fwc_ref_watch.sv
module fwc_ref_watch #(
    parameter int unsigned TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_edge,
    output logic ref_lost
);
    localparam int unsigned TO_W = $clog2(TIMEOUT + 1);
    localparam logic [TO_W-1:0] TO_LIMIT = TO_W'(TIMEOUT);

    logic [TO_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || ref_edge)          idle_cnt <= '0;
        else if (idle_cnt != TO_LIMIT) idle_cnt <= idle_cnt + 1'b1;
    end

    assign ref_lost = (idle_cnt == TO_LIMIT);
endmodule

// File: rtl/fwc_gate_counter.sv
module fwc_gate_counter #(
    parameter int unsigned GATE_REFS = 1024,
    parameter int unsigned CNT_W     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge,
    input  logic             ref_lost,
    output logic             close,
    output logic [CNT_W-1:0] meas
);
    localparam int unsigned EDGE_W = $clog2(GATE_REFS + 1);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(GATE_REFS - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

    logic              armed;
    logic [EDGE_W-1:0] edges;
    logic [CNT_W-1:0]  cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            edges <= '0;
            cyc   <= '0;
            close <= 1'b0;
            meas  <= '0;
        end else begin
            close <= 1'b0;
            if (ref_edge) begin
                if (!armed) begin
                    armed <= 1'b1;
                    edges <= '0;
                    cyc   <= CNT_W'(1);
                end else if (edges == LAST_EDGE) begin
                    close <= 1'b1;
                    meas  <= cyc;
                    edges <= '0;
                    cyc   <= CNT_W'(1);
                end else begin
                    edges <= edges + 1'b1;
                    if (cyc != CNT_MAX) cyc <= cyc + 1'b1;
                end
            end else if (ref_lost) begin
                armed <= 1'b0;
                edges <= '0;
                cyc   <= '0;
            end else if (armed && cyc != CNT_MAX) begin
                cyc <= cyc + 1'b1;
            end
        end
    end

    // R7
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !ref_edge && !ref_lost) |=> $stable(edges));

    // R8
    lost_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_lost && !ref_edge) |=> !close && !armed);
endmodule

// File: rtl/fwc_judge.sv
module fwc_judge
    import fwc_pkg::*;
#(
    parameter int unsigned GATE_REFS = 1024,
    parameter int unsigned CNT_W     = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rate_low,
    input  logic             ref_half,
    input  logic             close,
    input  logic [CNT_W-1:0] meas,
    input  logic             ref_lost,
    output ctl_out_t         ctl_q
);
    logic [CNT_W-1:0] lo_tab [4];
    logic [CNT_W-1:0] hi_tab [4];

    for (genvar s = 0; s < 4; s++) begin : g_win
        localparam longint unsigned EXP = gate_expect(GATE_REFS, 2'(s));
        localparam longint unsigned TOL = gate_tol(GATE_REFS, 2'(s));
        assign lo_tab[s] = CNT_W'(EXP - TOL);
        assign hi_tab[s] = CNT_W'(EXP + TOL);
    end

    logic [1:0]       sel;
    logic [CNT_W-1:0] lo_sel;
    logic [CNT_W-1:0] hi_sel;
    verdict_e         verd;

    assign sel    = {ref_half, rate_low};
    assign lo_sel = lo_tab[sel];
    assign hi_sel = hi_tab[sel];

    always_comb begin
        if (meas < lo_sel)      verd = VERD_LOW;
        else if (meas > hi_sel) verd = VERD_HIGH;
        else                    verd = VERD_IN;
    end

    always_ff @(posedge clk) begin
        if (rst || ref_lost) ctl_q <= CTL_IDLE;
        else if (close)      ctl_q <= verdict_to_ctl(verd);
    end

    // R6
    steer_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl_q.steer_up && ctl_q.steer_dn));

    // R6
    lock_pd_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lock != ctl_q.pd_disable);

    // R4
    low_steer_chk: assert property (@(posedge clk) disable iff (rst)
        (close && !ref_lost && meas < lo_sel) |=> ctl_q.steer_up && !ctl_q.lock);

    // R5
    high_steer_chk: assert property (@(posedge clk) disable iff (rst)
        (close && !ref_lost && meas > hi_sel) |=> ctl_q.steer_dn && !ctl_q.lock);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!close && !ref_lost) |=> $stable(ctl_q));

    // R8
    lost_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ref_lost |=> !ctl_q.lock && !ctl_q.steer_up && !ctl_q.steer_dn);
endmodule

// File: rtl/freq_window_chk.sv
module freq_window_chk
    import fwc_pkg::*;
#(
    parameter int unsigned GATE_REFS   = 1024,
    parameter int unsigned TIMEOUT     = 256,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic rate_low,
    input  logic ref_half,
    output logic lock,
    output logic pd_disable,
    output logic steer_up,
    output logic steer_dn
);
    // largest ratio is 32; double it for headroom before saturation
    localparam int unsigned CNT_W = $clog2(GATE_REFS * 64 + 1);

    logic             ref_edge;
    logic             ref_lost;
    logic             close;
    logic [CNT_W-1:0] meas;
    ctl_out_t         ctl;

    fwc_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ref_edge(ref_edge)
    );

    fwc_ref_watch #(.TIMEOUT(TIMEOUT)) watch_i (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .ref_lost(ref_lost)
    );

    fwc_gate_counter #(.GATE_REFS(GATE_REFS), .CNT_W(CNT_W)) gate_i (
        .clk(clk), .rst(rst), .ref_edge(ref_edge), .ref_lost(ref_lost),
        .close(close), .meas(meas)
    );

    fwc_judge #(.GATE_REFS(GATE_REFS), .CNT_W(CNT_W)) judge_i (
        .clk(clk), .rst(rst), .rate_low(rate_low), .ref_half(ref_half),
        .close(close), .meas(meas), .ref_lost(ref_lost), .ctl_q(ctl)
    );

    assign lock       = ctl.lock;
    assign pd_disable = ctl.pd_disable;
    assign steer_up   = ctl.steer_up;
    assign steer_dn   = ctl.steer_dn;
endmodule

// File: tb/freq_window_chk_tb_top.sv
module freq_window_chk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GATE       = 1024;
    localparam int TMO        = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic rate_low = 1'b1;
    logic ref_half = 1'b0;
    logic lock, pd_disable, steer_up, steer_dn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [3:0] v;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    event pushed;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_window_chk #(.GATE_REFS(GATE), .TIMEOUT(TMO)) dut_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .rate_low(rate_low), .ref_half(ref_half),
        .lock(lock), .pd_disable(pd_disable), .steer_up(steer_up), .steer_dn(steer_dn)
    );

    // packing {lock, pd_disable, steer_up, steer_dn}
    localparam logic [3:0] V_IDLE = 4'b0100;
    localparam logic [3:0] V_IN   = 4'b1000;
    localparam logic [3:0] V_UP   = 4'b0110;
    localparam logic [3:0] V_DN   = 4'b0101;

    task automatic compare(input logic [3:0] want, input string req);
        logic [3:0] got;
        got = {lock, pd_disable, steer_up, steer_dn};
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: outputs {lock,pd,up,dn} got %b expected %b at %0t", req, got, want, $time);
        end
        n_checks++; // R6 invariant on every sample
        if ((steer_up && steer_dn) || (lock === pd_disable)) begin
            n_fail++;
            $display("FAIL R6: got {lock,pd,up,dn}=%b expected exclusive steer and pd=!lock", got);
        end
    endtask

    function automatic int ratio_now();
        int rdiv, bdiv;
        rdiv = ref_half ? 128 : 64;
        bdiv = rate_low ? 16 : 4;
        return rdiv / bdiv;
    endfunction

    // one gate worth of reference periods; extra spreads +/-1 cycle over the first |extra| periods
    task automatic send_gate(input int extra, input bit push, input bit do_mid,
                             input logic [3:0] mid_v, input string req);
        int ratio, tol, mag, sgn;
        exp_t e;
        ratio = ratio_now();
        tol   = (GATE * ratio * 1000) / 1000000;
        mag   = (extra < 0) ? -extra : extra;
        sgn   = (extra < 0) ? -1 : 1;
        for (int i = 0; i < GATE; i++) begin
            int p;
            p = ratio + ((i < mag) ? sgn : 0);
            ref_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            ref_in = 1'b0;
            repeat (p - p / 2) @(negedge clk);
            if (do_mid && i == GATE / 2) compare(mid_v, {req, " mid-gate"});
        end
        if (push) begin
            if (extra < -tol)     e.v = V_UP;
            else if (extra > tol) e.v = V_DN;
            else                  e.v = V_IN;
            e.req = req;
            exp_q.push_back(e);
            -> pushed;
        end
    endtask

    // monitor: result appears a few cycles after the closing edge that starts the next gate
    initial begin
        forever begin
            exp_t e;
            @(pushed);
            repeat (20) @(negedge clk);
            e = exp_q.pop_front();
            compare(e.v, e.req);
        end
    end

    task automatic outage();
        ref_in = 1'b0;
        repeat (TMO + 50) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected run end");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare(V_IDLE, "R1 reset state");

        // ratio 4 (rate_low=1, ref_half=0): expected 4096, tolerance 4
        send_gate(0,  1, 1, V_IDLE, "R9 no lock before first gate; R3 exact count");
        send_gate(4,  1, 1, V_IN,   "R3 upper edge +4 in window; R7 hold");
        send_gate(5,  1, 0, V_IN,   "R5 +5 above window");
        send_gate(-4, 1, 1, V_DN,   "R3 lower edge -4 clears steer; R7 hold");
        send_gate(-5, 1, 0, V_IN,   "R4 -5 below window");
        send_gate(0,  1, 1, V_UP,   "R3 recovery after steer_up; R7 hold");
        send_gate(0,  0, 1, V_IN,   "R7 hold before outage");
        outage();
        compare(V_IDLE, "R8 reference lost");

        // ratio 16 (rate_low=0, ref_half=0): expected 16384, tolerance 16
        rate_low = 1'b0;
        send_gate(16,  1, 1, V_IDLE, "R2 ratio 16 +16 in window; R9 no lock after loss");
        send_gate(-17, 1, 0, V_IN,   "R2 R4 ratio 16 -17 below window");
        send_gate(0,   1, 1, V_UP,   "R2 ratio 16 back in window");
        send_gate(0,   0, 1, V_IN,   "R7 hold before second outage");
        outage();
        compare(V_IDLE, "R8 reference lost again");

        // ratio 8 (rate_low=1, ref_half=1): expected 8192, tolerance 8
        rate_low = 1'b1;
        ref_half = 1'b1;
        send_gate(9, 1, 1, V_IDLE, "R2 R5 ratio 8 +9 above window");
        send_gate(8, 1, 0, V_DN,   "R2 R3 ratio 8 +8 in window");
        send_gate(0, 0, 1, V_IN,   "R7 hold final");
        ref_in = 1'b0;
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule